// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block is a synchronous, synthesizable model of the control side of a byte-alterable nonvolatile memory. The memory has an asynchronous parallel bus: an active-low select, output enable and write enable, an address, and an 8-bit data path. The bidirectional data pins are split here into a write-data input, a read-data output and a drive enable. All bus pins pass through two-flop synchronisers. Read and write bus cycles are decoded from the synchronised signals.

Accepted byte loads collect in a page buffer. One page holds 2^PAGE_W bytes. The high address bits name the page, and the first load of a sequence fixes it. Each accepted write start reopens a load window of LOAD_WIN_CYC clock cycles. When the window closes with no new accepted write start, a self-timed programming phase of PROG_CYC cycles begins. In that phase, only the loaded bytes are copied into the storage array. While programming runs, every read returns a status byte instead of array data. A host detects the end of programming either by comparing bit 7 of that byte with the last byte it wrote, or by seeing bit 6 stop alternating.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset, mem_rdrive is 0 and, with ARRAY_CLEAR=1, every array location reads as 0.
- R2: mem_rdrive is 1 exactly when mem_sel_n and mem_oe_n were both low two clock edges earlier, as seen through the synchronisers; otherwise it is 0.
- R3: A write cycle is active while select and write enable are low and output enable is high. The address is taken when this condition begins, which is at the later of the two falling edges. The data is the value present in the last active cycle, which ends at the earlier of the two rising edges.
- R4: All bytes loaded into one page within a load sequence appear in the array at {page, offset} after programming ends. Up to 2^PAGE_W bytes can be loaded, in any offset order.
- R5: Programming lasts exactly PROG_CYC cycles. A load whose page (address bits AW-1..PAGE_W) differs from the page of the first load in the sequence is ignored.
- R6: Each accepted write start restarts the load window. Programming begins when LOAD_WIN_CYC cycles pass after the last accepted write start with no write cycle in progress. Loads spaced closer than the window all belong to one sequence, even if the sequence as a whole lasts longer than the window.
- R7: During programming, every read returns the inverse of bit DW-1 of the last accepted byte in bit DW-1.
- R8: During programming, bit DW-2 of the read data changes at the end of each read cycle, and bits DW-3..0 are 0. Outside programming, bit DW-2 does not change.
- R9: Write cycles started during programming have no effect on the array.
- R10: Array locations that were not loaded in a sequence keep their previous contents after programming.
- R11: After programming ends, reads return the stored array data again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_sel_n | input | 1 | Active-low device select |
| mem_oe_n | input | 1 | Active-low output enable |
| mem_we_n | input | 1 | Active-low write enable |
| mem_addr | input | AW | Byte address; upper bits name the page |
| mem_wdata | input | DW | Write data from the bus |
| mem_rdata | output | DW | Read data or, while programming, the status byte |
| mem_rdrive | output | 1 | Drive enable for the data pins during a read |

## Verification
The assertions check four things on every cycle. The drive enable follows select and output enable after two edges. The status byte shows the inverted last bit 7 and zero reserved bits. The alternating bit holds still outside programming. No load and no array write falls at the wrong phase, and each programming phase is exactly PROG_CYC cycles long. The bench scenarios cover what a property cannot see: which address and which data a write cycle captures, and whether a whole page survives a load sequence longer than the window. They also show that foreign-page loads, writes during programming and unloaded locations leave the array unchanged. Every location is read back across two full passes of page programming.

// File: rtl/epw_pkg.sv
package epw_pkg;

   typedef enum logic {
      PH_LOAD = 1'b0,
      PH_PROG = 1'b1
   } phase_e;

   localparam int STATUS_POLL_OFS   = 1;  // bit DW-1
   localparam int STATUS_TOGGLE_OFS = 2;  // bit DW-2

endpackage

// File: rtl/epw_sync.sv
module epw_sync #(
   parameter int   W       = 1,
   parameter logic RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("epw_sync: W must be at least 1");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic st1, st2;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               st1 <= RST_VAL;
               st2 <= RST_VAL;
            end else begin
               st1 <= d[i];
               st2 <= st1;
            end
         end
         assign q[i] = st2;
      end
   endgenerate

endmodule

// File: rtl/epw_bus_decode.sv
module epw_bus_decode #(
   parameter int AW = 15,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic          wr_start,
   output logic          wr_end,
   output logic          wr_active,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          rd_active,
   output logic          rd_end
);

   logic          wr_q, rd_q;
   logic [AW-1:0] addr_hold;
   logic [DW-1:0] data_hold;

   // write needs select and write enable low with outputs off
   assign wr_active = !sel_n && !we_n && oe_n;
   assign rd_active = !sel_n && !oe_n;

   assign wr_start  = wr_active && !wr_q;   // later of the two falls
   assign wr_end    = !wr_active && wr_q;   // earlier of the two rises
   assign rd_end    = !rd_active && rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q      <= 1'b0;
         rd_q      <= 1'b0;
         addr_hold <= '0;
         data_hold <= '0;
      end else begin
         wr_q <= wr_active;
         rd_q <= rd_active;
         if (wr_start)
            addr_hold <= addr;
         if (wr_active)
            data_hold <= din;
      end
   end

   assign wr_addr = addr_hold;
   assign wr_data = data_hold;

endmodule

// File: rtl/epw_page_buf.sv
module epw_page_buf #(
   parameter int PW = 7,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          ld_en,
   input  logic [PW-1:0] ld_off,
   input  logic [DW-1:0] ld_data,
   input  logic [PW-1:0] rd_idx,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data
);

   localparam int DEPTH = 1 << PW;

   logic [DW-1:0]    slot [DEPTH];
   logic [DEPTH-1:0] loaded;

   always_ff @(posedge clk) begin
      if (!rst_n)
         loaded <= '0;
      else if (clr)
         loaded <= '0;
      else if (ld_en)
         loaded[ld_off] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (ld_en)
         slot[ld_off] <= ld_data;
   end

   assign rd_valid = loaded[rd_idx];
   assign rd_data  = slot[rd_idx];

endmodule

// File: rtl/epw_seq.sv
module epw_seq #(
   parameter int PW           = 7,
   parameter int LOAD_WIN_CYC = 5000,
   parameter int PROG_CYC     = 150000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_start,
   input  logic          wr_active,
   output logic          busy,
   output logic          commit_en,
   output logic [PW-1:0] commit_idx,
   output logic          prog_done
);
   import epw_pkg::*;

   localparam int DEPTH = 1 << PW;
   localparam int WCW   = $clog2(LOAD_WIN_CYC + 1);
   localparam int PCW   = $clog2(PROG_CYC + 1);

   phase_e          phase;
   logic            pend;
   logic [WCW-1:0]  win_cnt;
   logic [PCW-1:0]  prog_cnt;
   logic            win_over, expire;

   assign win_over  = (win_cnt == WCW'(LOAD_WIN_CYC - 1));
   assign expire    = (phase == PH_LOAD) && pend && !wr_active && !acc_start && win_over;
   assign prog_done = (phase == PH_PROG) && (prog_cnt == PCW'(PROG_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_LOAD;
         pend     <= 1'b0;
         win_cnt  <= '0;
         prog_cnt <= '0;
      end else begin
         case (phase)
            PH_LOAD: begin
               if (acc_start) begin
                  pend    <= 1'b1;
                  win_cnt <= '0;
               end else if (expire) begin
                  phase    <= PH_PROG;
                  pend     <= 1'b0;
                  prog_cnt <= '0;
               end else if (pend && !win_over) begin
                  win_cnt <= win_cnt + 1'b1;
               end
            end
            default: begin
               if (prog_done)
                  phase <= PH_LOAD;
               else
                  prog_cnt <= prog_cnt + 1'b1;
            end
         endcase
      end
   end

   assign busy       = (phase == PH_PROG);
   assign commit_en  = busy && (32'(prog_cnt) < DEPTH);
   assign commit_idx = prog_cnt[PW-1:0];

endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl #(
   parameter int AW           = 11,
   parameter int DW           = 8,
   parameter int PAGE_W       = 7,
   parameter int LOAD_WIN_CYC = 5000,
   parameter int PROG_CYC     = 150000,
   parameter bit ARRAY_CLEAR  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mem_sel_n,
   input  logic          mem_oe_n,
   input  logic          mem_we_n,
   input  logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_wdata,
   output logic [DW-1:0] mem_rdata,
   output logic          mem_rdrive
);
   import epw_pkg::*;

   localparam int WORDS = 1 << AW;
   localparam int TAG_W = AW - PAGE_W;

   generate
      if (PAGE_W < 1 || PAGE_W >= AW) begin : g_bad_page
         $error("eeprom_page_ctrl: PAGE_W must lie in 1..AW-1");
      end
      if (DW < 3) begin : g_bad_dw
         $error("eeprom_page_ctrl: DW must be at least 3");
      end
      if (LOAD_WIN_CYC < 2) begin : g_bad_win
         $error("eeprom_page_ctrl: LOAD_WIN_CYC must be at least 2");
      end
      if (PROG_CYC <= (1 << PAGE_W)) begin : g_bad_prog
         $error("eeprom_page_ctrl: PROG_CYC must exceed the page size");
      end
   endgenerate

   // ---------------- synchronisers ----------------
   logic [2:0]    ctl_s;
   logic          sel_s, oe_s, we_s;
   logic [AW-1:0] addr_s;
   logic [DW-1:0] data_s;

   epw_sync #(.W(3), .RST_VAL(1'b1)) u_sync_ctl (
      .clk (clk), .rst_n (rst_n),
      .d   ({mem_sel_n, mem_oe_n, mem_we_n}),
      .q   (ctl_s)
   );
   epw_sync #(.W(AW), .RST_VAL(1'b0)) u_sync_addr (
      .clk (clk), .rst_n (rst_n), .d (mem_addr), .q (addr_s)
   );
   epw_sync #(.W(DW), .RST_VAL(1'b0)) u_sync_data (
      .clk (clk), .rst_n (rst_n), .d (mem_wdata), .q (data_s)
   );
   assign {sel_s, oe_s, we_s} = ctl_s;

   // ---------------- bus decode ----------------
   logic          wr_start, wr_end, wr_active, rd_active, rd_end;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;

   epw_bus_decode #(.AW(AW), .DW(DW)) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_n     (sel_s),
      .oe_n      (oe_s),
      .we_n      (we_s),
      .addr      (addr_s),
      .din       (data_s),
      .wr_start  (wr_start),
      .wr_end    (wr_end),
      .wr_active (wr_active),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_active (rd_active),
      .rd_end    (rd_end)
   );

   // ---------------- load acceptance ----------------
   logic             busy, commit_en, prog_done;
   logic [PAGE_W-1:0] commit_idx;
   logic             acc_start, acc_flag, ld_en;
   logic             pg_valid;
   logic [TAG_W-1:0] pg_tag;
   logic             last_msb;
   logic             tog;

   assign acc_start = wr_start && !busy &&
                      (!pg_valid || (addr_s[AW-1:PAGE_W] == pg_tag));
   assign ld_en     = wr_end && acc_flag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_flag <= 1'b0;
         pg_valid <= 1'b0;
         pg_tag   <= '0;
         last_msb <= 1'b0;
         tog      <= 1'b0;
      end else begin
         if (wr_start)
            acc_flag <= acc_start;
         else if (wr_end)
            acc_flag <= 1'b0;

         if (prog_done) begin
            pg_valid <= 1'b0;
         end else if (ld_en && !pg_valid) begin
            pg_valid <= 1'b1;
            pg_tag   <= wr_addr[AW-1:PAGE_W];
         end

         if (ld_en)
            last_msb <= wr_data[DW-1];

         if (busy && rd_end)
            tog <= !tog;
      end
   end

   // ---------------- sequencer and page buffer ----------------
   epw_seq #(
      .PW           (PAGE_W),
      .LOAD_WIN_CYC (LOAD_WIN_CYC),
      .PROG_CYC     (PROG_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_start  (acc_start),
      .wr_active  (wr_active),
      .busy       (busy),
      .commit_en  (commit_en),
      .commit_idx (commit_idx),
      .prog_done  (prog_done)
   );

   logic          slot_valid;
   logic [DW-1:0] slot_data;

   epw_page_buf #(.PW(PAGE_W), .DW(DW)) u_pbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (prog_done),
      .ld_en    (ld_en),
      .ld_off   (wr_addr[PAGE_W-1:0]),
      .ld_data  (wr_data),
      .rd_idx   (commit_idx),
      .rd_valid (slot_valid),
      .rd_data  (slot_data)
   );

   // ---------------- storage array ----------------
   logic          arr_we;
   logic [AW-1:0] arr_waddr;
   logic [DW-1:0] arr [WORDS];

   assign arr_we    = commit_en && slot_valid;
   assign arr_waddr = {pg_tag, commit_idx};

   generate
      if (ARRAY_CLEAR) begin : g_arr_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < WORDS; i++)
                  arr[i] <= '0;
            end else if (arr_we) begin
               arr[arr_waddr] <= slot_data;
            end
         end
      end else begin : g_arr_plain
         always_ff @(posedge clk) begin
            if (arr_we)
               arr[arr_waddr] <= slot_data;
         end
      end
   endgenerate

   // ---------------- read path ----------------
   logic [DW-1:0] status_byte;

   always_comb begin
      status_byte = '0;
      status_byte[DW-STATUS_POLL_OFS]   = !last_msb;
      status_byte[DW-STATUS_TOGGLE_OFS] = tog;
   end

   assign mem_rdata  = busy ? status_byte : arr[addr_s];
   assign mem_rdrive = rd_active;

endmodule

// File: rtl/epw_checker.sv
module epw_checker #(
   parameter int DW       = 8,
   parameter int PROG_CYC = 150000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sel_n,
   input logic          oe_n,
   input logic          drive,
   input logic [DW-1:0] rdata,
   input logic          busy,
   input logic          tog,
   input logic          ld_en,
   input logic [DW-1:0] ld_data,
   input logic          arr_we
);

   logic chk_last_msb;
   int   busy_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_last_msb <= 1'b0;
         busy_len     <= 0;
      end else begin
         if (ld_en)
            chk_last_msb <= ld_data[DW-1];
         busy_len <= busy ? busy_len + 1 : 0;
      end
   end

   AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> (!$past(sel_n, 2) && !$past(oe_n, 2)));                // R2
   AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel_n, 2) || $past(oe_n, 2)) |-> !drive);                 // R2
   AST_POLL_BIT_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && drive) |-> (rdata[DW-1] != chk_last_msb));              // R7
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && drive) |-> (rdata[DW-3:0] == '0));                      // R8
   AST_TOGGLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(tog));                                         // R8
   AST_NO_LOAD_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ld_en);                                                // R9
   AST_COMMIT_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);                                                // R4
   AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == PROG_CYC));                         // R5

endmodule

bind eeprom_page_ctrl epw_checker #(
   .DW       (DW),
   .PROG_CYC (PROG_CYC)
) u_epw_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel_n   (mem_sel_n),
   .oe_n    (mem_oe_n),
   .drive   (mem_rdrive),
   .rdata   (mem_rdata),
   .busy    (busy),
   .tog     (tog),
   .ld_en   (ld_en),
   .ld_data (wr_data),
   .arr_we  (arr_we)
);

// File: tb/test_eeprom_page_ctrl.sv
module test_eeprom_page_ctrl;

   localparam int AW    = 6;
   localparam int DW    = 8;
   localparam int PW    = 3;
   localparam int PSZ   = 1 << PW;
   localparam int NPG   = 1 << (AW - PW);
   localparam int WIN   = 40;
   localparam int PROG  = 60;
   localparam int WORDS = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rdrive;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [DW-1:0] expm [WORDS];

   always #2 clk = ~clk;

   eeprom_page_ctrl #(
      .AW(AW), .DW(DW), .PAGE_W(PW),
      .LOAD_WIN_CYC(WIN), .PROG_CYC(PROG), .ARRAY_CLEAR(1'b1)
   ) i_eeprom_page_ctrl (
      .clk(clk), .rst_n(rst_n),
      .mem_sel_n(sel_n), .mem_oe_n(oe_n), .mem_we_n(we_n),
      .mem_addr(addr), .mem_wdata(wdata),
      .mem_rdata(rdata), .mem_rdrive(rdrive)
   );

   function automatic logic [DW-1:0] pat_a(input int a);
      return DW'(a * 37 + 5);
   endfunction
   function automatic logic [DW-1:0] pat_b(input int a);
      return DW'(a * 53 + 129);
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic negs(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_we(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = AW'(a); wdata = d; sel_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
      negs(1); we_n = 1'b0;
      negs(4); we_n = 1'b1;
      negs(1); sel_n = 1'b1;
      negs(3);
   endtask

   task automatic read_at(input int a, output logic [DW-1:0] v, output logic drv);
      @(negedge clk);
      addr = AW'(a); sel_n = 1'b0; oe_n = 1'b0;
      negs(5);
      v = rdata; drv = rdrive;
      sel_n = 1'b1; oe_n = 1'b1;
      negs(4);
   endtask

   task automatic wait_prog();
      negs(WIN + PROG + 30);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         report();
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v, v1, v2;
      logic drv;
      for (int i = 0; i < WORDS; i++) expm[i] = '0;

      negs(4);
      rst_n = 1'b1;
      negs(3);
      // R1 reset state
      check("R1 drive after reset", DW'(rdrive), '0);
      for (int a = 0; a < WORDS; a += 9) begin
         read_at(a, v, drv);
         check("R1 cleared array", v, '0);
      end

      // R2 drive only with select and output enable both low
      @(negedge clk); sel_n = 1'b0; oe_n = 1'b1; negs(4);
      check("R2 drive, oe high", DW'(rdrive), '0);
      sel_n = 1'b1; oe_n = 1'b0; negs(4);
      check("R2 drive, select high", DW'(rdrive), '0);
      oe_n = 1'b1; negs(3);
      read_at(0, v, drv);
      check("R2 drive during read", DW'(drv), 8'd1);

      // pass 1: full pages, descending offsets (R4, R6)
      for (int p = 0; p < NPG; p++) begin
         for (int o = PSZ - 1; o >= 0; o--) begin
            write_we(p * PSZ + o, pat_a(p * PSZ + o));
            expm[p * PSZ + o] = pat_a(p * PSZ + o);
         end
         wait_prog();
      end
      for (int a = 0; a < WORDS; a++) begin
         read_at(a, v, drv);
         check("R4/R6 full page commit", v, expm[a]);
      end

      // pass 2: even offsets only, with a foreign-page load in between
      for (int p = 0; p < NPG; p++) begin
         for (int o = 0; o < PSZ; o += 2) begin
            write_we(p * PSZ + o, pat_b(p * PSZ + o));
            expm[p * PSZ + o] = pat_b(p * PSZ + o);
            if (o == 2)
               write_we(((p + 1) % NPG) * PSZ + 1, 8'hEE);  // R5 ignored
         end
         wait_prog();
      end
      for (int a = 0; a < WORDS; a++) begin
         read_at(a, v, drv);
         if ((a % PSZ) == 1)
            check("R5 foreign page load ignored", v, expm[a]);
         else if ((a % 2) == 1)
            check("R10 unloaded location kept", v, expm[a]);
         else
            check("R4 partial page commit", v, expm[a]);
      end

      // status during programming (R6 R7 R8 R9)
      write_we(2 * PSZ + 3, 8'h5A);
      write_we(2 * PSZ + 4, 8'hC3);
      expm[2 * PSZ + 3] = 8'h5A;
      expm[2 * PSZ + 4] = 8'hC3;
      negs(WIN + 6);
      read_at(2 * PSZ + 4, v1, drv);
      check("R6 window expired, R7 bit7 inverted", DW'(v1[7]), 8'd0);
      check("R8 reserved bits zero", DW'(v1[5:0]), '0);
      check("R2 drive while busy", DW'(drv), 8'd1);
      read_at(2 * PSZ + 4, v2, drv);
      check("R8 toggle bit changes", DW'(v2[6]), DW'(!v1[6]));
      check("R7 bit7 stays inverted", DW'(v2[7]), 8'd0);
      write_we(5 * PSZ, 8'h77);                        // R9 ignored
      read_at(0, v, drv);
      check("R7 status on other address", DW'(v[7]), 8'd0);
      check("R8 toggle bit changes again", DW'(v[6]), DW'(v1[6]));
      wait_prog();
      read_at(2 * PSZ + 4, v, drv);
      check("R11 true data after programming", v, 8'hC3);
      read_at(2 * PSZ + 4, v2, drv);
      check("R11 data stable, no toggling", v2, 8'hC3);
      read_at(5 * PSZ, v, drv);
      check("R9 write while busy ignored", v, expm[5 * PSZ]);

      // R3: select-controlled cycle, address at select fall, data before select rise
      @(negedge clk);
      addr = AW'(6'h12); wdata = 8'h3C; oe_n = 1'b1; sel_n = 1'b1; we_n = 1'b0;
      negs(3);
      addr = AW'(6'h2D); wdata = 8'h96;
      negs(1); sel_n = 1'b0;
      negs(4); sel_n = 1'b1;
      negs(1); addr = AW'(6'h12); wdata = 8'hF0;
      negs(3); we_n = 1'b1;
      expm[6'h2D] = 8'h96;
      wait_prog();
      read_at(6'h2D, v, drv);
      check("R3 address at later fall, data at earlier rise", v, 8'h96);
      read_at(6'h12, v, drv);
      check("R3 early address not written", v, expm[6'h12]);

      // final sweep
      for (int a = 0; a < WORDS; a++) begin
         read_at(a, v, drv);
         check("R10/R11 final contents", v, expm[a]);
      end

      done = 1'b1;
      report();
      $finish;
   end

endmodule